// File: doc/BRIEF.md
# Float-to-Integer Converter with Selectable Rounding

This unit turns one IEEE-754 operand, single or double precision, into a 32-bit integer. The integer can be signed or unsigned. A 2-bit mode field picks the rounding for each operation: ties away from zero, nearest with ties to even, toward plus infinity, or toward minus infinity. A separate truncate select forces rounding toward zero whatever the mode field holds. A flush-to-zero enable makes denormal operands count as exact zero. The result comes with an invalid flag and an inexact flag. Operations that name an unsupported precision are rejected and raise no flags.

The datapath is combinational. One output register sits at the edge, so a result appears one cycle after its request. The operand is first sorted into one of four classes: `CLS_ZERO`, `CLS_FINITE`, `CLS_INF` and `CLS_NAN`. A `unique case` on that class then picks the output path:
- `CLS_ZERO` gives 0 with no flags.
- `CLS_FINITE` rounds and then saturates.
- `CLS_INF` saturates.
- `CLS_NAN` gives 0 with invalid set.

The class is decided again for every operation, so no state carries over between operations. The only sequencing is the reset state followed by the registered result.

Top module: `f2i_conv`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low. The other outputs update only for valid requests.
- R2: When `in_trunc`=0, `in_rmode` selects the rounding: 0 means ties away from zero, 1 means nearest with ties to even, 2 means toward +inf, and 3 means toward -inf.
- R3: When `in_trunc`=1, the value is rounded toward zero whatever `in_rmode` holds.
- R4: `in_size` 2 converts a single-precision operand taken from `in_bits[31:0]`, ignoring `in_bits[63:32]`. `in_size` 3 converts a double-precision operand from `in_bits[63:0]`. `in_size` 0 or 1 sets `out_reject`, with result 0 and both flags clear.
- R5: With `in_signed`=1, a rounded value above 2^31-1 gives 0x7FFFFFFF and a rounded value below -2^31 gives 0x80000000, each with invalid set. Any other value gives its two's complement.
- R6: With `in_signed`=0, a rounded value above 2^32-1 gives 0xFFFFFFFF with invalid set. A negative value that rounds to a nonzero magnitude gives 0 with invalid set. A negative value that rounds to zero gives 0 with only inexact set, and only if the value was not exact.
- R7: A NaN operand, quiet or signalling, of either sign, gives 0 with invalid set.
- R8: An infinite operand saturates by its sign, as in R5 and R6, with invalid set.
- R9: When `in_ftz`=1, a denormal operand gives 0 with no flags. When `in_ftz`=0, it is a tiny nonzero value and rounds by the mode.
- R10: Inexact is set exactly when the rounded result differs from the operand and invalid is clear. Invalid and inexact are never both set.
- R11: During and right after reset, `out_valid`, `out_result`, `out_invalid`, `out_inexact` and `out_reject` are all 0.
- R12: +0 and -0 give 0 with no flags in every mode and format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_bits | input | 64 | Raw operand bits |
| in_size | input | 2 | Precision select: 2 = single, 3 = double |
| in_signed | input | 1 | 1 = signed result, 0 = unsigned result |
| in_rmode | input | 2 | Rounding mode field |
| in_trunc | input | 1 | Force rounding toward zero |
| in_ftz | input | 1 | Treat denormals as zero |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Integer result |
| out_invalid | output | 1 | Invalid operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_reject | output | 1 | Unsupported precision |

## Verification
Each operand is converted under all four mode codes plus truncation, for both signed and unsigned output.

The operand patterns separate different behaviours:
- Exact halfway values such as ±0.5, 1.5, 2.5 and 3.5 separate ties-away from ties-even.
- Non-halfway fractions separate the two directed modes from each other and from truncation.
- Values just inside and just outside 2^31, -2^31 and 2^32 pin the saturation edges and the point where inexact gives way to invalid.
- Small negative fractions expose the rule that an unsigned result of zero is inexact rather than invalid.
- Signed zeros, infinities, both NaN kinds and denormals with flush on and off cover the non-finite and tiny classes.
- Single-precision operands with garbage upper bits check that only the low word is decoded.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;
    localparam int MANT_W     = DBL_FRAC_W + 1;
    localparam int EXPV_W     = 13;
    localparam int INT_W      = 32;
    localparam int MAG_W      = INT_W + 2;

    localparam logic [1:0] SZ_SINGLE = 2'd2;
    localparam logic [1:0] SZ_DOUBLE = 2'd3;

    typedef enum logic [1:0] {
        CLS_ZERO   = 2'd0,
        CLS_FINITE = 2'd1,
        CLS_INF    = 2'd2,
        CLS_NAN    = 2'd3
    } f2i_class_e;

    typedef enum logic [1:0] {
        RND_AWAY = 2'd0,
        RND_EVEN = 2'd1,
        RND_UP   = 2'd2,
        RND_DOWN = 2'd3
    } f2i_rmode_e;

    // Operand brought to a common form: value = mant * 2^(exp - (MANT_W-1))
    typedef struct packed {
        logic              sign;
        f2i_class_e        cls;
        logic [EXPV_W-1:0] exp;
        logic [MANT_W-1:0] mant;
    } f2i_unp_t;

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] raw,
    input  logic                  ftz,
    output f2i_unp_t              unp
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int PAD  = MANT_W - 1 - FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = raw[EXP_W+FRAC_W-1 -: EXP_W];
    assign frac_f = raw[FRAC_W-1:0];

    always_comb begin
        unp.sign = raw[EXP_W+FRAC_W];
        unp.cls  = CLS_ZERO;
        unp.exp  = '0;
        unp.mant = '0;
        if (&exp_f) begin
            unp.cls = (|frac_f) ? CLS_NAN : CLS_INF;
        end else if (exp_f == '0) begin
            if ((|frac_f) && !ftz) begin
                unp.cls  = CLS_FINITE;
                unp.exp  = EXPV_W'(1) - EXPV_W'(BIAS);
                unp.mant = MANT_W'({1'b0, frac_f}) << PAD;
            end
        end else begin
            unp.cls  = CLS_FINITE;
            unp.exp  = EXPV_W'(exp_f) - EXPV_W'(BIAS);
            unp.mant = MANT_W'({1'b1, frac_f}) << PAD;
        end
    end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  f2i_unp_t         unp,
    input  logic [1:0]       rmode,
    input  logic             trunc,
    output logic [MAG_W-1:0] mag,
    output logic             lost,
    output logic             huge
);
    logic signed [EXPV_W-1:0] e;
    logic [EXPV_W-1:0]        shw;
    logic [5:0]               sh;
    logic [MANT_W-1:0]        lo_mask, frac, half;
    logic [MAG_W-1:0]         ipart;
    logic                     guard, sticky, inc;

    assign e   = $signed(unp.exp);
    assign shw = EXPV_W'(MANT_W - 1) - unp.exp;
    assign sh  = shw[5:0];

    always_comb begin
        huge    = 1'b0;
        ipart   = '0;
        guard   = 1'b0;
        sticky  = 1'b0;
        lo_mask = '0;
        frac    = '0;
        half    = '0;
        if (e > $signed(EXPV_W'(INT_W))) begin
            huge = 1'b1;
        end else if (e >= 0) begin
            ipart   = MAG_W'(unp.mant >> sh);
            lo_mask = (MANT_W'(1) << sh) - MANT_W'(1);
            frac    = unp.mant & lo_mask;
            half    = MANT_W'(1) << (sh - 6'd1);
            guard   = |(frac & half);
            sticky  = |(frac & (half - MANT_W'(1)));
        end else if (e == -1) begin
            guard  = unp.mant[MANT_W-1];
            sticky = |unp.mant[MANT_W-2:0];
        end else begin
            sticky = |unp.mant;
        end
    end

    always_comb begin
        if (trunc) begin
            inc = 1'b0;
        end else begin
            unique case (f2i_rmode_e'(rmode))
                RND_AWAY: inc = guard;
                RND_EVEN: inc = guard & (sticky | ipart[0]);
                RND_UP:   inc = (guard | sticky) & ~unp.sign;
                RND_DOWN: inc = (guard | sticky) & unp.sign;
            endcase
        end
    end

    assign mag  = ipart + MAG_W'(inc);
    assign lost = guard | sticky;
endmodule

// File: rtl/f2i_sat.sv
module f2i_sat
    import f2i_pkg::*;
(
    input  f2i_class_e       cls,
    input  logic             sign,
    input  logic             is_signed,
    input  logic [MAG_W-1:0] mag,
    input  logic             lost,
    input  logic             huge,
    output logic [INT_W-1:0] result,
    output logic             invalid,
    output logic             inexact
);
    localparam logic [MAG_W-1:0] SMAX_MAG = MAG_W'({1'b0, {(INT_W-1){1'b1}}});
    localparam logic [MAG_W-1:0] SMIN_MAG = MAG_W'({1'b1, {(INT_W-1){1'b0}}});
    localparam logic [MAG_W-1:0] UMAX_MAG = MAG_W'({INT_W{1'b1}});

    logic [INT_W-1:0] clamp;
    logic             over;

    always_comb begin
        if (sign) clamp = is_signed ? {1'b1, {(INT_W-1){1'b0}}} : '0;
        else      clamp = is_signed ? {1'b0, {(INT_W-1){1'b1}}} : '1;
    end

    always_comb begin
        if (huge)           over = 1'b1;
        else if (is_signed) over = sign ? (mag > SMIN_MAG) : (mag > SMAX_MAG);
        else                over = sign ? (mag != '0)      : (mag > UMAX_MAG);
    end

    always_comb begin
        result  = '0;
        invalid = 1'b0;
        unique case (cls)
            CLS_ZERO: begin
                result = '0;
            end
            CLS_NAN: begin
                invalid = 1'b1;
            end
            CLS_INF: begin
                result  = clamp;
                invalid = 1'b1;
            end
            CLS_FINITE: begin
                if (over) begin
                    result  = clamp;
                    invalid = 1'b1;
                end else if (sign) begin
                    result = is_signed ? (INT_W'(0) - mag[INT_W-1:0]) : '0;
                end else begin
                    result = mag[INT_W-1:0];
                end
            end
        endcase
        inexact = (cls == CLS_FINITE) & lost & ~invalid;
    end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
    import f2i_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [63:0]      in_bits,
    input  logic [1:0]       in_size,
    input  logic             in_signed,
    input  logic [1:0]       in_rmode,
    input  logic             in_trunc,
    input  logic             in_ftz,
    output logic             out_valid,
    output logic [31:0]      out_result,
    output logic             out_invalid,
    output logic             out_inexact,
    output logic             out_reject
);
    f2i_unp_t         unp_s, unp_d, unp;
    logic [MAG_W-1:0] mag;
    logic             lost, huge, reject;
    logic [INT_W-1:0] res;
    logic             inv, inx;

    f2i_unpack #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W)) u_unp_s (
        .raw (in_bits[SGL_EXP_W+SGL_FRAC_W:0]),
        .ftz (in_ftz),
        .unp (unp_s)
    );

    f2i_unpack #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W)) u_unp_d (
        .raw (in_bits),
        .ftz (in_ftz),
        .unp (unp_d)
    );

    assign reject = (in_size != SZ_SINGLE) && (in_size != SZ_DOUBLE);
    assign unp    = (in_size == SZ_DOUBLE) ? unp_d : unp_s;

    f2i_round u_round (
        .unp   (unp),
        .rmode (in_rmode),
        .trunc (in_trunc),
        .mag   (mag),
        .lost  (lost),
        .huge  (huge)
    );

    f2i_sat u_sat (
        .cls       (unp.cls),
        .sign      (unp.sign),
        .is_signed (in_signed),
        .mag       (mag),
        .lost      (lost),
        .huge      (huge),
        .result    (res),
        .invalid   (inv),
        .inexact   (inx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
            out_reject  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_reject  <= reject;
                out_result  <= reject ? '0 : res;
                out_invalid <= inv & ~reject;
                out_inexact <= inx & ~reject;
            end
        end
    end
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] in_bits,
    input logic [1:0]  in_size,
    input logic        in_ftz,
    input logic        out_valid,
    input logic [31:0] out_result,
    input logic        out_invalid,
    input logic        out_inexact,
    input logic        out_reject
);
    logic op_nan, op_den;

    always_comb begin
        op_nan = 1'b0;
        op_den = 1'b0;
        if (in_size == 2'd3) begin
            op_nan = (&in_bits[62:52]) && (|in_bits[51:0]);
            op_den = (in_bits[62:52] == '0) && (|in_bits[51:0]);
        end else if (in_size == 2'd2) begin
            op_nan = (&in_bits[30:23]) && (|in_bits[22:0]);
            op_den = (in_bits[30:23] == '0) && (|in_bits[22:0]);
        end
    end

    assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_reject_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_reject) |-> (out_result == '0 && !out_invalid && !out_inexact));

    assert_clamp_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_result == 32'h0 || out_result == 32'h7FFF_FFFF ||
                                        out_result == 32'h8000_0000 || out_result == 32'hFFFF_FFFF));

    assert_nan_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_nan) |=> (out_result == '0 && out_invalid));

    assert_ftz_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ftz && op_den) |=> (out_result == '0 && !out_invalid && !out_inexact));

    assert_flags_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_invalid && out_inexact));
endmodule

bind f2i_conv f2i_conv_chk u_chk (.*);

// File: tb/f2i_conv_tb.sv
module f2i_conv_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_bits;
    logic [1:0]  in_size;
    logic        in_signed;
    logic [1:0]  in_rmode;
    logic        in_trunc;
    logic        in_ftz;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;
    logic        out_inexact;
    logic        out_reject;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    f2i_conv u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
        .in_size(in_size), .in_signed(in_signed), .in_rmode(in_rmode),
        .in_trunc(in_trunc), .in_ftz(in_ftz), .out_valid(out_valid),
        .out_result(out_result), .out_invalid(out_invalid),
        .out_inexact(out_inexact), .out_reject(out_reject)
    );

    // Behavioural reference built on real arithmetic
    task automatic model(input logic [63:0] b, input logic [1:0] sz, input bit sgn,
                         input logic [1:0] rm, input bit tr, input bit ftz,
                         output logic [31:0] r, output bit inv, output bit inx, output bit rej);
        real v, a, fa, d, m;
        bit neg, is_nan, is_inf, den, odd;
        longint mi;
        logic [63:0] db;
        r = 0; inv = 0; inx = 0; rej = 0;
        if (sz < 2) begin
            rej = 1;
            return;
        end
        if (sz == 2'd3) begin
            neg    = b[63];
            is_nan = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
            is_inf = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
            den    = (b[62:52] == 0);
            v      = $bitstoreal(b);
        end else begin
            neg    = b[31];
            is_nan = (b[30:23] == 8'hFF) && (b[22:0] != 0);
            is_inf = (b[30:23] == 8'hFF) && (b[22:0] == 0);
            den    = (b[30:23] == 0);
            if (den) begin
                v = real'(b[22:0]) * (2.0 ** (-149));
                if (neg) v = -v;
            end else if (!is_nan && !is_inf) begin
                db = {b[31], 11'(b[30:23]) + 11'd896, b[22:0], 29'd0};
                v  = $bitstoreal(db);
            end else begin
                v = 0.0;
            end
        end
        a = (v < 0.0) ? -v : v;
        if (den && ftz) a = 0.0;
        if (is_nan) begin
            inv = 1;
            return;
        end
        if (is_inf || a >= 2.0 ** 40) begin
            inv = 1;
            if (sgn) r = neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
            else     r = neg ? 32'h0 : 32'hFFFF_FFFF;
            return;
        end
        fa  = $floor(a);
        d   = a - fa;
        odd = (fa / 2.0 - $floor(fa / 2.0)) != 0.0;
        if (tr)            m = fa;
        else if (rm == 0)  m = (d >= 0.5) ? fa + 1.0 : fa;
        else if (rm == 1)  m = (d > 0.5 || (d == 0.5 && odd)) ? fa + 1.0 : fa;
        else if (rm == 2)  m = (!neg && d > 0.0) ? fa + 1.0 : fa;
        else               m = (neg && d > 0.0) ? fa + 1.0 : fa;
        mi = longint'(m);
        if (sgn) begin
            if (!neg && mi > 64'sd2147483647)     begin r = 32'h7FFF_FFFF; inv = 1; end
            else if (neg && mi > 64'sd2147483648) begin r = 32'h8000_0000; inv = 1; end
            else r = neg ? 32'(-mi) : 32'(mi);
        end else begin
            if (neg) begin
                r = 0;
                if (mi != 0) inv = 1;
            end else if (mi > 64'sd4294967295) begin
                r = 32'hFFFF_FFFF; inv = 1;
            end else r = 32'(mi);
        end
        inx = (d > 0.0) && !inv;
    endtask

    task automatic apply(input logic [63:0] b, input logic [1:0] sz, input bit sgn,
                         input logic [1:0] rm, input bit tr, input bit ftz, input string tag);
        logic [31:0] er;
        bit ei, ex, ej;
        @(negedge clk);
        in_valid = 1; in_bits = b; in_size = sz; in_signed = sgn;
        in_rmode = rm; in_trunc = tr; in_ftz = ftz;
        model(b, sz, sgn, rm, tr, ftz, er, ei, ex, ej);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1) begin
            failures++;
            $display("FAIL R1 out_valid got %b exp 1", out_valid);
        end
        checks++;
        if (out_result !== er || out_invalid !== ei || out_inexact !== ex || out_reject !== ej) begin
            failures++;
            $display("FAIL %s bits=%h sz=%0d sgn=%0b rm=%0d tr=%0b ftz=%0b got r=%h inv=%0b inx=%0b rej=%0b exp r=%h inv=%0b inx=%0b rej=%0b",
                     tag, b, sz, sgn, rm, tr, ftz, out_result, out_invalid, out_inexact,
                     out_reject, er, ei, ex, ej);
        end
    endtask

    // Every mode plus truncation, both output formats
    task automatic run_val(input logic [63:0] b, input logic [1:0] sz, input bit ftz, input string tag);
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 4; k++) apply(b, sz, s[0], 2'(k), 1'b0, ftz, tag);
            apply(b, sz, s[0], 2'd2, 1'b1, ftz, "R3");
            apply(b, sz, s[0], 2'd0, 1'b1, ftz, "R3");
        end
    endtask

    task automatic run_dbl(input real v, input string tag);
        run_val($realtobits(v), 2'd3, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; in_valid = 0; in_bits = 0; in_size = 0; in_signed = 0;
        in_rmode = 0; in_trunc = 0; in_ftz = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 0 || out_result !== 0 || out_invalid !== 0 || out_inexact !== 0 || out_reject !== 0) begin
            failures++;
            $display("FAIL R11 reset outputs got v=%b r=%h i=%b x=%b j=%b exp all zero",
                     out_valid, out_result, out_invalid, out_inexact, out_reject);
        end
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (out_valid !== 0 || out_result !== 0) begin
            failures++;
            $display("FAIL R11 after reset got v=%b r=%h exp 0", out_valid, out_result);
        end

        // R2 halfway and fractional cases
        run_dbl(2.5, "R2");   run_dbl(-2.5, "R2");  run_dbl(0.5, "R2");
        run_dbl(-0.5, "R2");  run_dbl(1.5, "R2");   run_dbl(3.5, "R2");
        run_dbl(2.25, "R2");  run_dbl(-7.75, "R2"); run_dbl(-3.5, "R2");
        // R12 signed zeros
        run_val(64'h0000_0000_0000_0000, 2'd3, 1'b0, "R12");
        run_val(64'h8000_0000_0000_0000, 2'd3, 1'b0, "R12");
        run_val(64'hFFFF_FFFF_8000_0000, 2'd2, 1'b0, "R12");
        // R5 signed edges and large values
        run_dbl(2147483647.5, "R5");  run_dbl(-2147483648.5, "R5");
        run_dbl(2147483648.0, "R5");  run_dbl(-2147483649.0, "R5");
        run_dbl(-2147483648.0, "R5"); run_dbl(1.0e20, "R5"); run_dbl(-1.0e20, "R5");
        // R6 unsigned edges
        run_dbl(4294967295.4, "R6"); run_dbl(4294967295.5, "R6");
        run_dbl(4294967296.0, "R6"); run_dbl(-0.3, "R6"); run_dbl(-1.0, "R6");
        // R7 NaN kinds
        run_val(64'h7FF8_0000_0000_0000, 2'd3, 1'b0, "R7");
        run_val(64'hFFF0_0000_0000_0001, 2'd3, 1'b0, "R7");
        run_val(64'h0000_0000_7FC0_0000, 2'd2, 1'b0, "R7");
        // R8 infinities
        run_val(64'h7FF0_0000_0000_0000, 2'd3, 1'b0, "R8");
        run_val(64'hFFF0_0000_0000_0000, 2'd3, 1'b0, "R8");
        run_val(64'h0000_0000_FF80_0000, 2'd2, 1'b0, "R8");
        // R9 denormals with and without flush
        for (int f = 0; f < 2; f++) begin
            run_val(64'h0000_0000_0000_0001, 2'd3, f[0], "R9");
            run_val(64'h8000_0000_0000_ABCD, 2'd3, f[0], "R9");
            run_val(64'h1234_5678_0000_0001, 2'd2, f[0], "R9");
            run_val(64'h0000_0000_8000_0001, 2'd2, f[0], "R9");
        end
        // R10 exact versus inexact
        run_dbl(100.0, "R10"); run_dbl(123456.789, "R10"); run_dbl(-65535.0, "R10");
        // R4 single precision with garbage upper word
        run_val(64'hDEAD_BEEF_4020_0000, 2'd2, 1'b0, "R4");
        run_val(64'hA5A5_A5A5_BFC0_0000, 2'd2, 1'b0, "R4");
        run_val(64'h0000_0000_3F00_0000, 2'd2, 1'b0, "R4");
        run_val(64'hFFFF_FFFF_4F32_D05E, 2'd2, 1'b0, "R4");
        run_val(64'h0000_0000_CF00_0000, 2'd2, 1'b0, "R4");
        run_val(64'h0000_0000_4F80_0000, 2'd2, 1'b0, "R4");
        // R4 rejected sizes
        run_val(64'h4004_0000_0000_0000, 2'd0, 1'b0, "R4");
        run_val(64'h4004_0000_4020_0000, 2'd1, 1'b0, "R4");

        // R1 idle cycle drops valid
        @(negedge clk);
        in_valid = 0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 idle out_valid got %b exp 0", out_valid);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule